// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block holds the request, mask and in-service state of one eight-line programmable interrupt controller. Each input line can be set to edge or level triggering on its own. An edge-triggered line latches a request when its input rises. A level-triggered line's request simply follows the input.

The unmasked requests are searched in a rotating order that starts at a movable base line. The winner is compared with the highest-priority line already in service. The interrupt output to the processor is raised, one clock later, only when the winner outranks every line in service.

An acknowledge strobe moves the current winner into service. A command port applies end-of-interrupt clears, either to the highest-priority line in service or to a named line, and moves the rotation base. Bus decoding, cascading and vector generation stay outside the block.

Top module: `irq_prio_resolver`

## Requirements
- R1: A line whose trigger bit is 0 (edge) sets its request bit on the clock at which its input is 1 and was 0 at the previous clock. The remembered previous level is 0 after reset. A request stays set while the input is held.
- R2: A line whose trigger bit is 1 (level) has its request bit equal to its input as sampled at the previous clock.
- R3: The candidates are the request bits with the mask bit clear. Relative index k names line (k + base) mod 8, and the set candidate with the smallest k wins. win_valid_o is 1 only when a candidate exists and either no line is in service or the candidate's relative index is strictly smaller than the in-service one. In that case win_line_o gives the winning line.
- R4: cpu_irq_o is a register that shows, one clock later, the value win_valid_o had.
- R5: When special fully nested mode is on, the in-service bit of cascade line 2 is left out of the in-service priority. A new request on line 2 can then win while line 2 is in service.
- R6: An acknowledge while win_valid_o is 1 sets the winner's in-service bit, unless auto-EOI is on. It clears the winner's request bit only on an edge line. An acknowledge while win_valid_o is 0 changes nothing.
- R7: When auto-EOI and rotate-on-auto-EOI are both on, an accepted acknowledge sets the base to (winner + 1) mod 8.
- R8: The command codes are as follows. 1 clears the highest-priority in-service bit in rotating order, considering all bits. 2 does the same and also sets the base to (that line + 1) mod 8. 3 clears the in-service bit of cmd_line_i. 4 clears that bit and sets the base to (cmd_line_i + 1) mod 8. 5 sets only the base, to (cmd_line_i + 1) mod 8. 0, 6 and 7 do nothing. Codes 1 and 2 do nothing when no line is in service.
- R9: When events coincide in one clock, a rising edge on an edge line keeps its request set even when an acknowledge of that line would clear it. The in-service register becomes (old & ~command clear) | acknowledge set. A base written by a command takes precedence over an auto-EOI rotation.
- R10: Reset clears the request, mask and in-service registers, the base, the previous levels and cpu_irq_o. The trigger-select register keeps its value through reset.
- R11: A mask write loads mask_data_i into the mask register at the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in_i | input | 8 | Raw interrupt input lines |
| lvl_wr_i | input | 1 | Write strobe for the trigger-select register |
| lvl_data_i | input | 8 | Trigger select, 1 = level, 0 = edge |
| mask_wr_i | input | 1 | Write strobe for the mask register |
| mask_data_i | input | 8 | New mask, 1 = line blocked |
| auto_eoi_i | input | 1 | Auto-EOI mode |
| rot_aeoi_i | input | 1 | Rotate base on auto-EOI |
| sfnm_i | input | 1 | Special fully nested mode |
| ack_i | input | 1 | Acknowledge strobe |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command code (R8) |
| cmd_line_i | input | 3 | Line operand of a command |
| cpu_irq_o | output | 1 | Registered interrupt request to the processor |
| win_valid_o | output | 1 | A winner outranks the lines in service |
| win_line_o | output | 3 | Winning line |
| irr_o | output | 8 | Request register |
| isr_o | output | 8 | In-service register |
| imr_o | output | 8 | Mask register |
| lvl_o | output | 8 | Trigger-select register |
| base_o | output | 3 | Rotation base |

## Verification
The acknowledge and the command port can both act on the in-service register and the base in the same clock. An acknowledge can also meet a fresh rising edge on the line it is clearing. The random phases drive acknowledges, commands and sparse input toggles independently, so these events coincide many times. A directed case forces an acknowledge on line 1 in the very clock its input rises again. Each clock is judged by comparing every register output with a bench model that applies the R9 merge rules.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  typedef enum logic [2:0] {
    CMD_NONE         = 3'd0,
    CMD_EOI_TOP      = 3'd1,
    CMD_EOI_TOP_ROT  = 3'd2,
    CMD_EOI_LINE     = 3'd3,
    CMD_EOI_LINE_ROT = 3'd4,
    CMD_SET_BASE     = 3'd5
  } cmd_e;

  // modular add of two indices already below n
  function automatic int wrap_idx(input int a, input int n);
    return (a >= n) ? a - n : a;
  endfunction
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NL = 8,
  localparam int IW = $clog2(NL)
) (
  input  logic [NL-1:0] bits_i,
  input  logic [IW-1:0] base_i,
  output logic          hit_o,
  output logic [IW-1:0] rel_o,
  output logic [IW-1:0] line_o
);
  import irq_prio_pkg::*;

  logic [NL-1:0] rot;

  always_comb begin
    for (int i = 0; i < NL; i++) begin
      rot[i] = bits_i[wrap_idx(i + int'(base_i), NL)];
    end
    hit_o = 1'b0;
    rel_o = '0;
    for (int i = NL - 1; i >= 0; i--) begin
      if (rot[i]) begin
        hit_o = 1'b1;
        rel_o = IW'(i);
      end
    end
    line_o = IW'(wrap_idx(int'(rel_o) + int'(base_i), NL));
  end
endmodule

// File: rtl/irq_req_capture.sv
module irq_req_capture #(
  parameter int NL = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] irq_in_i,
  input  logic [NL-1:0] lvl_i,
  input  logic [NL-1:0] clr_i,
  output logic [NL-1:0] irr_o
);
  logic [NL-1:0] prev_q, irr_q, irr_d, rise;

  always_comb begin
    rise  = irq_in_i & ~prev_q;
    irr_d = (lvl_i & irq_in_i) | (~lvl_i & ((irr_q & ~clr_i) | rise));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      irr_q  <= '0;
    end else begin
      prev_q <= irq_in_i;
      irr_q  <= irr_d;
    end
  end

  assign irr_o = irr_q;
endmodule

// File: rtl/irq_svc_ctrl.sv
module irq_svc_ctrl #(
  parameter int NL = 8,
  localparam int IW = $clog2(NL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] ack_set_i,
  input  logic          aeoi_rot_i,
  input  logic [IW-1:0] aeoi_line_i,
  input  logic          cmd_valid_i,
  input  logic [2:0]    cmd_op_i,
  input  logic [IW-1:0] cmd_line_i,
  output logic [NL-1:0] isr_o,
  output logic [IW-1:0] base_o
);
  import irq_prio_pkg::*;

  logic [NL-1:0] isr_q, isr_d, eoi_clr;
  logic [IW-1:0] base_q, base_d, cmd_base;
  logic          cmd_base_en;
  logic          top_hit;
  logic [IW-1:0] top_rel, top_line;

  irq_prio_enc #(.NL(NL)) u_top (
    .bits_i(isr_q), .base_i(base_q),
    .hit_o(top_hit), .rel_o(top_rel), .line_o(top_line)
  );

  always_comb begin
    eoi_clr     = '0;
    cmd_base_en = 1'b0;
    cmd_base    = '0;
    if (cmd_valid_i) begin
      case (cmd_e'(cmd_op_i))
        CMD_EOI_TOP: begin
          if (top_hit) eoi_clr = NL'(1) << top_line;
        end
        CMD_EOI_TOP_ROT: begin
          if (top_hit) begin
            eoi_clr     = NL'(1) << top_line;
            cmd_base_en = 1'b1;
            cmd_base    = IW'(wrap_idx(int'(top_line) + 1, NL));
          end
        end
        CMD_EOI_LINE: eoi_clr = NL'(1) << cmd_line_i;
        CMD_EOI_LINE_ROT: begin
          eoi_clr     = NL'(1) << cmd_line_i;
          cmd_base_en = 1'b1;
          cmd_base    = IW'(wrap_idx(int'(cmd_line_i) + 1, NL));
        end
        CMD_SET_BASE: begin
          cmd_base_en = 1'b1;
          cmd_base    = IW'(wrap_idx(int'(cmd_line_i) + 1, NL));
        end
        default: ;
      endcase
    end
    isr_d = (isr_q & ~eoi_clr) | ack_set_i;
    if (cmd_base_en)     base_d = cmd_base;
    else if (aeoi_rot_i) base_d = IW'(wrap_idx(int'(aeoi_line_i) + 1, NL));
    else                 base_d = base_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q  <= '0;
      base_q <= '0;
    end else begin
      isr_q  <= isr_d;
      base_q <= base_d;
    end
  end

  assign isr_o  = isr_q;
  assign base_o = base_q;
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver #(
  parameter int NL           = 8,
  parameter bit IS_MASTER    = 1'b1,
  parameter int CASCADE_LINE = 2,
  localparam int IW = $clog2(NL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] irq_in_i,
  input  logic          lvl_wr_i,
  input  logic [NL-1:0] lvl_data_i,
  input  logic          mask_wr_i,
  input  logic [NL-1:0] mask_data_i,
  input  logic          auto_eoi_i,
  input  logic          rot_aeoi_i,
  input  logic          sfnm_i,
  input  logic          ack_i,
  input  logic          cmd_valid_i,
  input  logic [2:0]    cmd_op_i,
  input  logic [IW-1:0] cmd_line_i,
  output logic          cpu_irq_o,
  output logic          win_valid_o,
  output logic [IW-1:0] win_line_o,
  output logic [NL-1:0] irr_o,
  output logic [NL-1:0] isr_o,
  output logic [NL-1:0] imr_o,
  output logic [NL-1:0] lvl_o,
  output logic [IW-1:0] base_o
);
  logic [NL-1:0] lvl_q, imr_q, irr, isr, isr_eff, ack_bit;
  logic [IW-1:0] base;
  logic          cand_hit, cur_hit, pend, ack_go, cpu_irq_q;
  logic [IW-1:0] cand_rel, cand_line, cur_rel, cur_line;

  // trigger select survives reset on purpose
  always_ff @(posedge clk) begin
    if (lvl_wr_i) lvl_q <= lvl_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         imr_q <= '0;
    else if (mask_wr_i) imr_q <= mask_data_i;
  end

  irq_req_capture #(.NL(NL)) u_req (
    .clk(clk), .rst_n(rst_n), .irq_in_i(irq_in_i), .lvl_i(lvl_q),
    .clr_i(ack_bit & ~lvl_q), .irr_o(irr)
  );

  irq_prio_enc #(.NL(NL)) u_cand (
    .bits_i(irr & ~imr_q), .base_i(base),
    .hit_o(cand_hit), .rel_o(cand_rel), .line_o(cand_line)
  );

  generate
    if (IS_MASTER) begin : g_master
      assign isr_eff = sfnm_i ? (isr & ~(NL'(1) << CASCADE_LINE)) : isr;
    end else begin : g_slave
      assign isr_eff = isr;
    end
  endgenerate

  irq_prio_enc #(.NL(NL)) u_cur (
    .bits_i(isr_eff), .base_i(base),
    .hit_o(cur_hit), .rel_o(cur_rel), .line_o(cur_line)
  );

  always_comb begin
    pend    = cand_hit && (!cur_hit || (cand_rel < cur_rel));
    ack_go  = ack_i && pend;
    ack_bit = ack_go ? (NL'(1) << cand_line) : '0;
  end

  irq_svc_ctrl #(.NL(NL)) u_svc (
    .clk(clk), .rst_n(rst_n),
    .ack_set_i(auto_eoi_i ? '0 : ack_bit),
    .aeoi_rot_i(ack_go && auto_eoi_i && rot_aeoi_i),
    .aeoi_line_i(cand_line),
    .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i), .cmd_line_i(cmd_line_i),
    .isr_o(isr), .base_o(base)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cpu_irq_q <= 1'b0;
    else        cpu_irq_q <= pend;
  end

  assign cpu_irq_o   = cpu_irq_q;
  assign win_valid_o = pend;
  assign win_line_o  = cand_line;
  assign irr_o       = irr;
  assign isr_o       = isr;
  assign imr_o       = imr_q;
  assign lvl_o       = lvl_q;
  assign base_o      = base;
endmodule

// File: rtl/irq_prio_resolver_chk.sv
module irq_prio_resolver_chk #(
  parameter int NL = 8,
  localparam int IW = $clog2(NL)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NL-1:0] irq_in_i,
  input logic          auto_eoi_i,
  input logic          ack_i,
  input logic          cmd_valid_i,
  input logic          cpu_irq_o,
  input logic          win_valid_o,
  input logic [IW-1:0] win_line_o,
  input logic [NL-1:0] irr_o,
  input logic [NL-1:0] isr_o,
  input logic [NL-1:0] imr_o,
  input logic [NL-1:0] lvl_o,
  input logic [IW-1:0] base_o
);
  // R3
  win_is_candidate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid_o |-> (irr_o[win_line_o] && !imr_o[win_line_o]));

  // R4
  irq_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq_o |-> ($past(irr_o & ~imr_o) != '0));

  // R6
  ack_enters_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && win_valid_o && !auto_eoi_i && !cmd_valid_i) |=> isr_o[$past(win_line_o)]);

  // R6
  ack_clears_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && win_valid_o && !lvl_o[win_line_o] && !irq_in_i[win_line_o])
      |=> !irr_o[$past(win_line_o)]);

  // R2
  level_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(lvl_o) |-> ((irr_o & lvl_o) == ($past(irq_in_i) & lvl_o)));

  // R7
  base_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid_i && !ack_i) |=> $stable(base_o));
endmodule

bind irq_prio_resolver irq_prio_resolver_chk #(.NL(NL)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in_i(irq_in_i), .auto_eoi_i(auto_eoi_i),
  .ack_i(ack_i), .cmd_valid_i(cmd_valid_i), .cpu_irq_o(cpu_irq_o),
  .win_valid_o(win_valid_o), .win_line_o(win_line_o), .irr_o(irr_o),
  .isr_o(isr_o), .imr_o(imr_o), .lvl_o(lvl_o), .base_o(base_o)
);

// File: tb/irq_prio_resolver_test.sv
`timescale 1ns/100ps
module irq_prio_resolver_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq_in, lvl_data, mask_data;
  logic       lvl_wr, mask_wr, aeoi, rot, sfnm, ack, cmd_valid;
  logic [2:0] cmd_op, cmd_line;
  logic       cpu_irq, win_valid;
  logic [2:0] win_line, base;
  logic [7:0] irr, isr, imr, lvl;

  int errors = 0;
  int checks = 0;

  // model state
  logic [7:0] m_irr, m_isr, m_imr, m_lvl, m_prev;
  logic [2:0] m_base;
  logic       m_cpu;

  always #2.5 clk = ~clk;

  irq_prio_resolver uut (
    .clk(clk), .rst_n(rst_n), .irq_in_i(irq_in), .lvl_wr_i(lvl_wr),
    .lvl_data_i(lvl_data), .mask_wr_i(mask_wr), .mask_data_i(mask_data),
    .auto_eoi_i(aeoi), .rot_aeoi_i(rot), .sfnm_i(sfnm), .ack_i(ack),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_line_i(cmd_line),
    .cpu_irq_o(cpu_irq), .win_valid_o(win_valid), .win_line_o(win_line),
    .irr_o(irr), .isr_o(isr), .imr_o(imr), .lvl_o(lvl), .base_o(base)
  );

  function automatic int first_rel(input logic [7:0] v, input logic [2:0] b);
    for (int k = 0; k < 8; k++) if (v[(k + b) % 8]) return k;
    return 8;
  endfunction

  function automatic logic m_pend(output logic [2:0] line);
    logic [7:0] se;
    int cr, ir;
    se = m_isr;
    if (sfnm) se[2] = 1'b0;
    cr = first_rel(m_irr & ~m_imr, m_base);
    ir = first_rel(se, m_base);
    line = 3'((cr + m_base) % 8);
    return (cr < 8) && (cr < ir);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all();
    logic [2:0] l;
    logic p;
    p = m_pend(l);
    chk("R1 R2 R6 irr", irr, m_irr);
    chk("R6 R8 isr", isr, m_isr);
    chk("R11 imr", imr, m_imr);
    chk("R7 R8 base", {5'd0, base}, {5'd0, m_base});
    chk("R3 R5 win_valid", {7'd0, win_valid}, {7'd0, p});
    if (p) chk("R3 win_line", {5'd0, win_line}, {5'd0, l});
    chk("R4 cpu_irq", {7'd0, cpu_irq}, {7'd0, m_cpu});
  endtask

  // check, drive, clock once, update model; returns at the next negedge
  task automatic step(input logic [7:0] in, input logic a, input logic cv,
                      input logic [2:0] op, input logic [2:0] ln,
                      input logic mw, input logic [7:0] md,
                      input logic lw, input logic [7:0] ld);
    logic [2:0] l, cb;
    logic p, cben;
    logic [7:0] set, clr, rise;
    int tr;
    check_all();
    irq_in = in; ack = a; cmd_valid = cv; cmd_op = op; cmd_line = ln;
    mask_wr = mw; mask_data = md; lvl_wr = lw; lvl_data = ld;
    p = m_pend(l);
    set = (a && p) ? (8'd1 << l) : 8'd0;
    rise = in & ~m_prev;
    clr = 8'd0; cben = 1'b0; cb = 3'd0;
    tr = first_rel(m_isr, m_base);
    if (cv) begin
      case (op)
        3'd1: if (tr < 8) clr = 8'd1 << ((tr + m_base) % 8);
        3'd2: if (tr < 8) begin
                clr = 8'd1 << ((tr + m_base) % 8);
                cben = 1'b1; cb = 3'((tr + m_base + 1) % 8);
              end
        3'd3: clr = 8'd1 << ln;
        3'd4: begin clr = 8'd1 << ln; cben = 1'b1; cb = ln + 3'd1; end
        3'd5: begin cben = 1'b1; cb = ln + 3'd1; end
        default: ;
      endcase
    end
    @(posedge clk);
    m_cpu = p;
    m_irr = (m_lvl & in) | (~m_lvl & ((m_irr & ~(set & ~m_lvl)) | rise));
    m_isr = (m_isr & ~clr) | (aeoi ? 8'd0 : set);
    if (cben) m_base = cb;
    else if (a && p && aeoi && rot) m_base = l + 3'd1;
    if (mw) m_imr = md;
    if (lw) m_lvl = ld;
    m_prev = in;
    @(negedge clk);
    irq_in = in; ack = 1'b0; cmd_valid = 1'b0; mask_wr = 1'b0; lvl_wr = 1'b0;
  endtask

  task automatic idle(input logic [7:0] in);
    step(in, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 8'd0, 1'b0, 8'd0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_irr = 0; m_isr = 0; m_imr = 0; m_base = 0; m_prev = 0; m_cpu = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    rst_n = 1'b0; irq_in = 0; ack = 0; cmd_valid = 0; cmd_op = 0; cmd_line = 0;
    mask_wr = 0; mask_data = 0; aeoi = 0; rot = 0; sfnm = 0;
    lvl_wr = 1'b1; lvl_data = 8'hA5;
    @(negedge clk);
    lvl_wr = 1'b0; m_lvl = 8'hA5;
    do_reset();
    // R10: reset state, trigger select kept
    check_all();
    chk("R10 lvl kept", lvl, 8'hA5);
    chk("R10 cpu_irq low", {7'd0, cpu_irq}, 8'd0);

    // R5: special fully nested lets line 2 nest on itself
    step(8'h00, 0, 0, 0, 0, 0, 0, 1, 8'h00);
    sfnm = 1'b1;
    idle(8'h04);
    step(8'h04, 1, 0, 0, 0, 0, 0, 0, 0);
    idle(8'h00);
    idle(8'h04);
    chk("R5 isr line2", isr, 8'h04);
    chk("R5 nested win", {7'd0, win_valid}, 8'd1);
    sfnm = 1'b0;
    #1;
    chk("R5 blocked without mode", {7'd0, win_valid}, 8'd0);
    idle(8'h04);
    chk("R4 cpu_irq follows", {7'd0, cpu_irq}, 8'd0);

    // R9: acknowledge of line 1 in the clock its input rises again
    do_reset();
    idle(8'h02);
    idle(8'h00);
    step(8'h02, 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R9 rise beats ack clear", irr, 8'h02);
    chk("R9 ack set", isr, 8'h02);

    // R7: auto-EOI with rotation
    do_reset();
    aeoi = 1'b1; rot = 1'b1;
    idle(8'h08);
    step(8'h08, 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R7 base moved", {5'd0, base}, 8'd4);
    chk("R7 isr untouched", isr, 8'h00);
    aeoi = 1'b0; rot = 1'b0;

    // R6: ack with no winner is ignored
    step(8'h08, 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R6 spurious ack", isr, 8'h00);

    // random phases
    for (int ph = 0; ph < 3; ph++) begin
      logic [7:0] in;
      aeoi = (ph == 1); rot = (ph == 1); sfnm = (ph == 2);
      in = irq_in;
      step(in, 0, 0, 0, 0, 0, 0, 1, 8'($urandom));
      for (int c = 0; c < 1500; c++) begin
        logic [7:0] md;
        in = in ^ (8'($urandom) & 8'($urandom) & 8'($urandom));
        md = 8'($urandom) & 8'($urandom) & 8'($urandom);
        step(in, ($urandom % 3) == 0, ($urandom % 4) == 0, 3'($urandom),
             3'($urandom), ($urandom % 16) == 0, md, 1'b0, 8'd0);
      end
    end
    check_all();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule